// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady series of period events for system timekeeping. A fixed divide-by-16 prescaler runs from the system clock and steps a 20-bit interval counter. The counter climbs from zero to a period limit that software programs, then wraps. Each wrap is one completed period. It raises a status flag and adds one to a 12-bit count of elapsed periods. A level interrupt follows the status flag while the interrupt enable is set. The interrupt line may be shared, so software reads the status flag to learn whether this timer is the source.

Software programs the block through a small register bus with a word address, write and read strobes, and 32-bit data. A mode register holds the period limit, a run enable and an interrupt enable. Two readouts return the running interval value packed with the elapsed-period count. The acknowledge readout clears the count and the pending status as a side effect. The observe readout leaves all state alone, so a free-running timestamp can be built from it without disturbing interrupt service. To stop the timer, software writes zero to the mode register. It then polls until the interval field reads zero before it starts the timer again.

Top module: `pit_top`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: The prescaler emits one step every 16 clock cycles. A running interval counter changes value only on such a step.
- R3: On each step the interval counter increments. When it is already at or above the period limit, it wraps to zero instead, so a period lasts (limit + 1) steps.
- R4: The mode register sits at byte offset 0x0. It holds the period limit in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. Every other bit reads as zero.
- R5: The readout words at offsets 0x8 and 0xC carry the interval value in bits 19:0 and the elapsed-period count in bits 31:20. The read data is zero in any cycle without a read strobe.
- R6: A read at offset 0x8 returns the readout word and clears both the elapsed-period count and the status flag.
- R7: A read at offset 0xC returns the same readout word and changes neither the count nor the status flag.
- R8: The status register at offset 0x4 shows in bit 0 a flag that sets when a period completes. The flag stays set until an acknowledging read.
- R9: The interrupt output is high exactly when the status flag and the interrupt enable are both set. The timer counts normally while the interrupt is disabled.
- R10: With the run enable cleared, a nonzero interval counter keeps stepping until it wraps (counting that period) and then holds at zero. If the limit is lowered below the current value, the next step wraps.
- R11: The elapsed-period count saturates at 4095 and does not wrap.
- R12: An acknowledging read in the same cycle as a period completion leaves a count of 1 and the status flag set.
- R13: Writes to offsets other than 0x0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong prescaler phase or a missed wrap moves the interval field of the observe readout within 16 cycles. Because the reference model is compared on every clock, such an error is caught at the first read that follows. An error in the elapsed count or the status flag shows up at the next status or readout access, and in the interrupt level in the same cycle. The costly corners are an acknowledge that coincides with a completion, a limit lowered below the running value, and saturation after 4095 periods. The bench steers into each of these on purpose by following its own model's prescaler phase.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int unsigned PIT_CNT_W  = 20;
    localparam int unsigned PIT_PCNT_W = 12;
    localparam int unsigned PIT_PRE_W  = 4;
    localparam int unsigned PIT_AW     = 4;
    localparam int unsigned PIT_DW     = 32;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VAL  = 2'd2,
        SEL_IMG  = 2'd3
    } pit_sel_e;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
    parameter int unsigned PRE_W = pit_pkg::PIT_PRE_W
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pre = s_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = &s_q.pre;

    // a step never repeats on back-to-back cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pit_core.sv
module pit_core #(
    parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
    parameter int unsigned PCNT_W = pit_pkg::PIT_PCNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [CNT_W-1:0]  limit,
    input  logic              ack,
    output logic [CNT_W-1:0]  cur,
    output logic [PCNT_W-1:0] pcnt,
    output logic              sts
);
    localparam logic [PCNT_W-1:0] PCNT_MAX = {PCNT_W{1'b1}};
    localparam logic [PCNT_W-1:0] PCNT_ONE = PCNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  cur;
        logic [PCNT_W-1:0] pcnt;
        logic              sts;
    } state_t;

    state_t s_d, s_q;
    logic   done;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (tick && (en || s_q.cur != '0)) begin
            if (s_q.cur >= limit) begin
                s_d.cur = '0;
                done    = 1'b1;
            end else begin
                s_d.cur = s_q.cur + 1'b1;
            end
        end
        if (ack) begin
            s_d.pcnt = done ? PCNT_ONE : '0;
            s_d.sts  = done;
        end else if (done) begin
            if (s_q.pcnt != PCNT_MAX) s_d.pcnt = s_q.pcnt + 1'b1;
            s_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.cur;
    assign pcnt = s_q.pcnt;
    assign sts  = s_q.sts;

    p_step_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.cur));
    p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && s_q.cur == '0) |=> s_q.cur == '0);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick) |=> (s_q.pcnt == '0 && !s_q.sts));
    p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pcnt == PCNT_MAX && !ack) |=> s_q.pcnt == PCNT_MAX);
    p_sts_from_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sts) |-> $past(tick));
    p_ack_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && tick && (en || s_q.cur != '0) && s_q.cur >= limit)
        |=> (s_q.pcnt == PCNT_ONE && s_q.sts));
endmodule

// File: rtl/pit_bus.sv
module pit_bus #(
    parameter int unsigned CNT_W   = pit_pkg::PIT_CNT_W,
    parameter int unsigned PCNT_W  = pit_pkg::PIT_PCNT_W,
    parameter int unsigned AW      = pit_pkg::PIT_AW,
    parameter int unsigned DW      = pit_pkg::PIT_DW,
    parameter int unsigned EN_BIT  = 24,
    parameter int unsigned IEN_BIT = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     wdata,
    input  logic [CNT_W-1:0]  cur,
    input  logic [PCNT_W-1:0] pcnt,
    input  logic              sts,
    output logic [DW-1:0]     rdata,
    output logic [CNT_W-1:0]  limit,
    output logic              en,
    output logic              ack,
    output logic              irq
);
    import pit_pkg::*;

    localparam int unsigned SEL_LSB = 2;

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             en;
        logic             ien;
    } state_t;

    state_t   s_d, s_q;
    pit_sel_e sel;
    logic [DW-1:0] word_q;

    assign sel = pit_sel_e'(addr[SEL_LSB +: 2]);

    always_comb begin
        s_d = s_q;
        if (wr && sel == SEL_MODE) begin
            s_d.limit = wdata[CNT_W-1:0];
            s_d.en    = wdata[EN_BIT];
            s_d.ien   = wdata[IEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        word_q = '0;
        if (rd) begin
            case (sel)
                SEL_MODE: begin
                    word_q[CNT_W-1:0] = s_q.limit;
                    word_q[EN_BIT]    = s_q.en;
                    word_q[IEN_BIT]   = s_q.ien;
                end
                SEL_STAT: word_q[0] = sts;
                default:  word_q = DW'({pcnt, cur});
            endcase
        end
    end

    assign rdata = word_q;
    assign limit = s_q.limit;
    assign en    = s_q.en;
    assign ack   = rd && sel == SEL_VAL;
    assign irq   = sts && s_q.ien;

    // with the interrupt disabled the line stays low whatever the status does
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ien |-> !irq);
    p_mode_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_MODE) |=> limit == $past(wdata[CNT_W-1:0]));
    p_other_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel != SEL_MODE) |=> $stable(limit) && $stable(en));
endmodule

// File: rtl/pit_top.sv
module pit_top #(
    parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
    parameter int unsigned PCNT_W = pit_pkg::PIT_PCNT_W,
    parameter int unsigned PRE_W  = pit_pkg::PIT_PRE_W,
    parameter int unsigned AW     = pit_pkg::PIT_AW,
    parameter int unsigned DW     = pit_pkg::PIT_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic              tick;
    logic              en;
    logic              ack;
    logic              sts;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W-1:0]  cur;
    logic [PCNT_W-1:0] pcnt;

    pit_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    pit_core #(.CNT_W(CNT_W), .PCNT_W(PCNT_W)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .en   (en),
        .limit(limit),
        .ack  (ack),
        .cur  (cur),
        .pcnt (pcnt),
        .sts  (sts)
    );

    pit_bus #(.CNT_W(CNT_W), .PCNT_W(PCNT_W), .AW(AW), .DW(DW)) u_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .wdata(bus_wdata),
        .cur  (cur),
        .pcnt (pcnt),
        .sts  (sts),
        .rdata(bus_rdata),
        .limit(limit),
        .en   (en),
        .ack  (ack),
        .irq  (irq)
    );
endmodule

// File: tb/tb_pit_top.sv
module tb_pit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 0;
    bit timeout = 0;

    // behavioural reference state
    int m_pre, m_cur, m_cnt, m_piv;
    bit m_sts, m_en, m_ien;

    always #4 clk = ~clk;

    pit_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cur = 0; m_cnt = 0; m_piv = 0;
            m_sts = 0; m_en = 0; m_ien = 0;
        end else begin
            bit done;
            bit tk;
            done = 0;
            tk = (m_pre == 15);
            m_pre = (m_pre + 1) % 16;
            if (tk && (m_en || m_cur != 0)) begin
                if (m_cur >= m_piv) begin m_cur = 0; done = 1; end
                else m_cur = m_cur + 1;
            end
            if (rd && addr[3:2] == 2'd2) begin
                m_cnt = done ? 1 : 0;
                m_sts = done;
            end else if (done) begin
                if (m_cnt < 4095) m_cnt = m_cnt + 1;
                m_sts = 1;
            end
            if (wr && addr[3:2] == 2'd0) begin
                m_piv = int'(wdata[19:0]);
                m_en  = wdata[24];
                m_ien = wdata[25];
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v;
        v = '0;
        if (rd) begin
            case (addr[3:2])
                2'd0: begin v[19:0] = m_piv[19:0]; v[24] = m_en; v[25] = m_ien; end
                2'd1: v[0] = m_sts;
                default: begin v[19:0] = m_cur[19:0]; v[31:20] = m_cnt[11:0]; end
            endcase
        end
        return v;
    endfunction

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        #1;
        if (live && rst_n) begin
            check("R5 R13 rdata", rdata, exp_rdata());
            check("R9 irq", {31'b0, irq}, {31'b0, m_sts & m_ien});
        end
    end

    task automatic drive(input logic [3:0] a, input logic w, input logic r, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = w; rd = r; wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) drive(4'h0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        drive(a, 1'b1, 1'b0, d);
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        drive(a, 1'b0, 1'b1, 32'h0);
        #2 v = rdata;
    endtask

    task automatic scenario();
        logic [31:0] v, v2;
        int changes, maxv;
        logic [19:0] prev;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R1 reset state
        read_reg(4'h0, v); check("R1 mode", v, 32'h0);
        read_reg(4'h4, v); check("R1 status", v, 32'h0);
        read_reg(4'h8, v); check("R1 value", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        // R4 field placement
        write_reg(4'h0, 32'hFFFF_FFFF);
        read_reg(4'h0, v); check("R4 mode fields", v, 32'h030F_FFFF);
        write_reg(4'h0, 32'h0);
        idle(40);
        read_reg(4'h8, v);
        idle(2);
        // R13 writes elsewhere ignored
        write_reg(4'h8, 32'h0300_0123);
        write_reg(4'hC, 32'h0100_0456);
        write_reg(4'h4, 32'h0100_0789);
        read_reg(4'h0, v); check("R13 mode unchanged", v, 32'h0);
        idle(40);
        read_reg(4'hC, v); check("R13 counter idle", {12'h0, v[19:0]}, 32'h0);
        // R2 R3 stepping, limit 2, interrupt off
        write_reg(4'h0, 32'h0100_0002);
        idle(1);
        changes = 0; maxv = 0;
        drive(4'hC, 1'b0, 1'b1, 32'h0);
        #2 prev = rdata[19:0];
        for (int i = 0; i < 64; i++) begin
            @(negedge clk); #2;
            if (rdata[19:0] != prev) changes++;
            if (int'(rdata[19:0]) > maxv) maxv = int'(rdata[19:0]);
            prev = rdata[19:0];
        end
        check("R2 steps in 64 cycles", changes, 4);
        check("R3 highest value", maxv, 2);
        // R8 R9
        read_reg(4'h4, v); check("R8 status set", v, 32'h1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        // R7 observe read keeps state
        read_reg(4'hC, v);
        check("R7 count nonzero", {31'b0, v[31:20] != 0}, 32'h1);
        read_reg(4'h4, v2); check("R7 status kept", v2, 32'h1);
        // R6 acknowledge
        read_reg(4'h8, v); check("R6 ack word", v, exp_rdata());
        read_reg(4'h4, v); check("R6 status after ack", v, {31'b0, m_sts});
        read_reg(4'hC, v); check("R6 count after ack", {20'h0, v[31:20]}, m_cnt);
        // R9 interrupt enabled
        write_reg(4'h0, 32'h0300_0003);
        idle(1);
        while (!m_sts) idle(1);
        #2 check("R9 irq high", {31'b0, irq}, 32'h1);
        read_reg(4'h8, v);
        idle(1);
        #2 check("R9 irq low after ack", {31'b0, irq}, {31'b0, m_sts});
        // R12 acknowledge on a completing step
        forever begin
            @(negedge clk);
            if (m_pre == 15 && m_cur >= m_piv) begin
                addr = 4'h8; rd = 1'b1; wr = 1'b0; break;
            end
            rd = 1'b0; wr = 1'b0;
        end
        read_reg(4'h4, v); check("R12 status stays", v, 32'h1);
        read_reg(4'hC, v); check("R12 count one", {20'h0, v[31:20]}, 32'h1);
        // R10 enable cleared mid-period
        write_reg(4'h0, 32'h0100_0009);
        while (m_cur != 5) idle(1);
        write_reg(4'h0, 32'h0000_0009);
        idle(16 * 12);
        read_reg(4'hC, v); check("R10 wrapped to zero", {12'h0, v[19:0]}, 32'h0);
        idle(48);
        read_reg(4'hC, v); check("R10 holds zero", {12'h0, v[19:0]}, 32'h0);
        // R10 limit lowered below the value
        write_reg(4'h0, 32'h0100_0009);
        while (m_cur != 6) idle(1);
        read_reg(4'h8, v);
        write_reg(4'h0, 32'h0);
        idle(20);
        read_reg(4'hC, v); check("R10 shrink wrap", {12'h0, v[19:0]}, 32'h0);
        read_reg(4'h4, v); check("R10 shrink counted", v, 32'h1);
        // R11 saturation, limit 0
        write_reg(4'h0, 32'h0100_0000);
        idle(16 * 4100);
        read_reg(4'hC, v); check("R11 saturated", {20'h0, v[31:20]}, 32'hFFF);
        read_reg(4'h8, v); check("R11 ack returns max", {20'h0, v[31:20]}, 32'hFFF);
        idle(4);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (190000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        live = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule